// File: doc/BRIEF.md
# Palette Colour Register Front End

This block is the register side of a 256-entry colour lookup table for a frame buffer. A 32-bit, write-only bus slave exposes a 16-byte window. Software first writes the entry number it wants to change. It then sends that entry's red, green and blue values one after another through a single shared data register. An internal sequencer keeps track of which colour component comes next. After the third component it moves on to the next entry by itself, so software can load the whole table with one index write followed by a stream of component writes.

The block holds the three 256 x 8 colour arrays. A lookup stream from the scanout path presents a pixel index and receives the 24-bit colour one clock later. The lookup stream has a valid signal in each direction and no ready. The block takes a request on every clock, and the scanout sink must accept every colour beat in the cycle it is valid, because nothing is held back. Bus reads complete but always return zero.

Top module: `palette_dac`

## Requirements
- R1: A write to word offset 0 (bus_addr = 0x0) loads the current entry index from bus_wdata[31:24] and restarts the component sequencer at red. The low 24 data bits are ignored.
- R2: Successive writes to word offset 1 (bus_addr = 0x4) store bus_wdata[31:24] into the red, then the green, then the blue component of the current entry.
- R3: The blue write increments the entry index modulo 256 (255 wraps to 0) and returns the sequencer to red.
- R4: Every bus read returns bus_rdata = 0.
- R5: A write is ignored when it targets offset 0x8 or 0xC, when bus_be is not 4'hF, or when bus_addr[1:0] is not zero. It changes no palette entry, no index and no sequencer step.
- R6: After reset, entries 0 to 254 read 0x000000 and entry 255 reads 0xFFFFFF. The index is 0 and the sequencer waits for red.
- R7: A lookup request (lk_valid high with lk_idx) at a clock edge gives col_valid high and col_rgb = {red, green, blue} (red in bits 23:16, blue in 7:0) for that index after that edge. col_valid is low in cycles with no request.
- R8: A component write becomes visible to a lookup presented on the following clock. A lookup at the same edge as the write returns the previous value.
- R9: An index write in the middle of a triple keeps the components already written, leaves the rest of that entry unchanged, and starts the next component at red of the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset inside the 16-byte window |
| bus_be | input | 4 | Byte enables; only 4'hF forms a valid access |
| bus_wdata | input | 32 | Write data; bits 31:24 carry the payload |
| bus_rdata | output | 32 | Read data, always zero |
| lk_valid | input | 1 | Lookup request valid |
| lk_idx | input | 8 | Pixel index to translate |
| col_valid | output | 1 | Colour result valid, one clock after a request |
| col_rgb | output | 24 | Colour result {red, green, blue} |

## Verification
The index register and the sequencer step cannot be read back, so any fault in them shows up only through the lookup port. A sequencer that is off by one step puts a component into the wrong colour lane. A wrong index puts a whole triple into the wrong entry. Either fault appears at the first lookup of the affected entries after the writes, one clock after that lookup is presented. The bench therefore follows every write pattern with lookups of the target entry and of its neighbours. A stuck reset value shows at the first lookup of entry 0 or entry 255.

// File: rtl/palette_pkg.sv
package palette_pkg;
  localparam int IDX_W  = 8;
  localparam int COMP_W = 8;
  localparam int NCOMP  = 3;

  typedef enum logic [1:0] {
    CMP_RED   = 2'd0,
    CMP_GREEN = 2'd1,
    CMP_BLUE  = 2'd2
  } comp_t;

  // word offsets inside the register window
  localparam logic [1:0] WORD_INDEX = 2'd0;
  localparam logic [1:0] WORD_COMP  = 2'd1;
endpackage

// File: rtl/palette_sequencer.sv
module palette_sequencer
  import palette_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int CW = COMP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_wr,
  input  logic          comp_wr,
  input  logic [CW-1:0] wr_byte,
  output logic [IW-1:0] cur_idx,
  output comp_t         cur_comp,
  output logic [NCOMP-1:0] comp_we
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_idx  <= '0;
      cur_comp <= CMP_RED;
    end else if (idx_wr) begin
      cur_idx  <= wr_byte[IW-1:0];
      cur_comp <= CMP_RED;
    end else if (comp_wr) begin
      unique case (cur_comp)
        CMP_RED:   cur_comp <= CMP_GREEN;
        CMP_GREEN: cur_comp <= CMP_BLUE;
        default: begin
          cur_comp <= CMP_RED;
          cur_idx  <= cur_idx + 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    comp_we = '0;
    if (comp_wr) comp_we[NCOMP-1-int'(cur_comp)] = 1'b1;
  end
endmodule

// File: rtl/palette_bank.sv
module palette_bank #(
  parameter int IW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] w_idx,
  input  logic [CW-1:0] w_val,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_idx,
  output logic [CW-1:0] rd_val
);
  localparam int DEPTH = 1 << IW;
  logic [CW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= (i == DEPTH - 1) ? {CW{1'b1}} : '0;
    end else if (we) begin
      mem[w_idx] <= w_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_val <= '0;
    else if (rd_en) rd_val <= mem[rd_idx];
  end
endmodule

// File: rtl/palette_dac.sv
module palette_dac
  import palette_pkg::*;
#(
  parameter int IW     = IDX_W,
  parameter int CW     = COMP_W,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                lk_valid,
  input  logic [IW-1:0]       lk_idx,
  output logic                col_valid,
  output logic [NCOMP*CW-1:0] col_rgb
);
  localparam int WORD_W = ADDR_W - 2;

  logic              full_word;
  logic [WORD_W-1:0] word_sel;
  logic              idx_wr, comp_wr;
  logic [CW-1:0]     pay_byte;
  logic [IW-1:0]     seq_idx;
  comp_t             seq_comp;
  logic [NCOMP-1:0]  bank_we;

  assign full_word = bus_sel && bus_wr && (&bus_be) && (bus_addr[1:0] == 2'b00);
  assign word_sel  = bus_addr[ADDR_W-1:2];
  assign idx_wr    = full_word && (word_sel == WORD_W'(WORD_INDEX));
  assign comp_wr   = full_word && (word_sel == WORD_W'(WORD_COMP));
  assign pay_byte  = bus_wdata[DATA_W-1 -: CW];
  assign bus_rdata = '0;

  palette_sequencer #(.IW(IW), .CW(CW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_wr   (idx_wr),
    .comp_wr  (comp_wr),
    .wr_byte  (pay_byte),
    .cur_idx  (seq_idx),
    .cur_comp (seq_comp),
    .comp_we  (bank_we)
  );

  for (genvar c = 0; c < NCOMP; c++) begin : g_bank
    palette_bank #(.IW(IW), .CW(CW)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (bank_we[c]),
      .w_idx  (seq_idx),
      .w_val  (pay_byte),
      .rd_en  (lk_valid),
      .rd_idx (lk_idx),
      .rd_val (col_rgb[c*CW +: CW])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) col_valid <= 1'b0;
    else        col_valid <= lk_valid;
  end
endmodule

// File: rtl/palette_dac_checker.sv
module palette_dac_checker #(
  parameter int IW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [3:0]    bus_be,
  input logic [31:0]   bus_wdata,
  input logic          lk_valid,
  input logic          col_valid,
  input logic [IW-1:0] seq_idx,
  input logic [1:0]    seq_comp,
  input logic [2:0]    bank_we
);
  logic good, w_idx, w_cmp, w_bad;
  assign good  = bus_sel && bus_wr && (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00);
  assign w_idx = good && (bus_addr[AW-1:2] == 0);
  assign w_cmp = good && (bus_addr[AW-1:2] == 1);
  assign w_bad = bus_sel && bus_wr && !w_idx && !w_cmp;

  p_index_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    w_idx |=> (seq_idx == $past(bus_wdata[31:24])) && (seq_comp == 2'd0));

  p_red_to_green_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (w_cmp && seq_comp == 2'd0) |=> (seq_comp == 2'd1) && $stable(seq_idx));

  p_green_to_blue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (w_cmp && seq_comp == 2'd1) |=> (seq_comp == 2'd2) && $stable(seq_idx));

  p_blue_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (w_cmp && seq_comp == 2'd2) |=> (seq_comp == 2'd0) && (seq_idx == IW'($past(seq_idx) + 1)));

  p_ignored_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    w_bad |-> (bank_we == 3'b000) ##1 ($stable(seq_idx) && $stable(seq_comp)));

  p_single_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));

  p_lookup_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> col_valid);

  p_lookup_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !col_valid);
endmodule

bind palette_dac palette_dac_checker #(.IW(IW), .AW(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .bus_wdata (bus_wdata),
  .lk_valid  (lk_valid),
  .col_valid (col_valid),
  .seq_idx   (seq_idx),
  .seq_comp  (seq_comp),
  .bank_we   (bank_we)
);

// File: tb/tb_palette_dac.sv
module tb_palette_dac;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        lk_valid = 1'b0;
  logic [7:0]  lk_idx = '0;
  logic        col_valid;
  logic [23:0] col_rgb;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  palette_dac dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [3:0] addr, logic [31:0] data, logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr; bus_be = be; bus_wdata = data;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic set_index(logic [7:0] idx);
    bus_write(4'h0, {idx, 24'hA5C3E1});
  endtask

  task automatic put_comp(logic [7:0] v);
    bus_write(4'h4, {v, 24'h5A3C1E});
  endtask

  task automatic lookup(logic [7:0] idx, output logic [23:0] rgb);
    @(negedge clk);
    lk_valid = 1'b1; lk_idx = idx;
    @(negedge clk);
    rgb = col_rgb;
    lk_valid = 1'b0;
  endtask

  task automatic expect_entry(string req, logic [7:0] idx, logic [23:0] exp);
    logic [23:0] got;
    lookup(idx, got);
    check(req, {8'h0, got}, {8'h0, exp});
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    check("R7 idle col_valid", {31'h0, col_valid}, 32'h0);
    expect_entry("R6 entry 0 black", 8'd0, 24'h000000);
    expect_entry("R6 entry 7 black", 8'd7, 24'h000000);
    expect_entry("R6 entry 254 black", 8'd254, 24'h000000);
    expect_entry("R6 entry 255 white", 8'd255, 24'hFFFFFF);
    // index reset to 0, sequencer at red: triple lands in entry 0
    put_comp(8'h0A); put_comp(8'h0B); put_comp(8'h0C);
    expect_entry("R6 index cleared", 8'd0, 24'h0A0B0C);
    put_comp(8'h01); put_comp(8'h02); put_comp(8'h03);
    expect_entry("R3 autoinc to 1", 8'd1, 24'h010203);
  endtask

  task automatic t_triple;
    set_index(8'd100);
    put_comp(8'h12);
    expect_entry("R2 red only", 8'd100, 24'h120000);
    put_comp(8'h34);
    expect_entry("R2 red green", 8'd100, 24'h123400);
    put_comp(8'h56);
    expect_entry("R1 R2 full triple", 8'd100, 24'h123456);
    expect_entry("R1 neighbour untouched", 8'd99, 24'h000000);
  endtask

  task automatic t_wrap;
    set_index(8'd255);
    put_comp(8'h21); put_comp(8'h22); put_comp(8'h23);
    put_comp(8'h31); put_comp(8'h32); put_comp(8'h33);
    expect_entry("R3 entry 255", 8'd255, 24'h212223);
    expect_entry("R3 wrap to 0", 8'd0, 24'h313233);
  endtask

  task automatic t_restart;
    set_index(8'd20);
    put_comp(8'hA1); put_comp(8'hA2);
    set_index(8'd21);
    put_comp(8'hB1); put_comp(8'hB2); put_comp(8'hB3);
    put_comp(8'hC1); put_comp(8'hC2); put_comp(8'hC3);
    expect_entry("R9 partial entry kept", 8'd20, 24'hA1A200);
    expect_entry("R9 restart at red", 8'd21, 24'hB1B2B3);
    expect_entry("R9 autoinc after restart", 8'd22, 24'hC1C2C3);
  endtask

  task automatic t_reads;
    logic [31:0] got;
    for (int a = 0; a < 16; a += 4) begin
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'(a); bus_be = 4'hF;
      #1 got = bus_rdata;
      check("R4 read zero", got, 32'h0);
      @(negedge clk);
      bus_sel = 1'b0;
    end
  endtask

  task automatic t_ignored;
    set_index(8'd50);
    put_comp(8'h11);
    bus_write(4'h8, 32'hEE000000);
    bus_write(4'hC, 32'hDD000000);
    bus_write(4'h4, 32'hCC000000, 4'h7);
    bus_write(4'h5, 32'hBB000000);
    bus_write(4'h0, 32'h77000000, 4'hE);
    expect_entry("R5 nothing stored", 8'd50, 24'h110000);
    put_comp(8'h22); put_comp(8'h33);
    expect_entry("R5 sequence intact", 8'd50, 24'h112233);
    expect_entry("R5 index not moved", 8'd51, 24'h000000);
    expect_entry("R5 index byte unused", 8'd119, 24'h000000);
  endtask

  task automatic t_lookup_timing;
    logic [23:0] got;
    set_index(8'd40);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h4; bus_be = 4'hF; bus_wdata = 32'h55000000;
    lk_valid = 1'b1; lk_idx = 8'd40;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    check("R7 col_valid after request", {31'h0, col_valid}, 32'h1);
    check("R8 same edge old value", {8'h0, col_rgb}, 32'h0);
    lk_idx = 8'd40;
    @(negedge clk);
    lk_valid = 1'b0;
    check("R8 next clock new value", {8'h0, col_rgb}, 32'h00550000);
    @(negedge clk);
    check("R7 col_valid drops", {31'h0, col_valid}, 32'h0);
    lookup(8'd100, got);
    check("R7 lookup colour", {8'h0, got}, 32'h00123456);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_triple();
    t_wrap();
    t_restart();
    t_reads();
    t_ignored();
    t_lookup_timing();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule